// File: doc/BRIEF.md
# Self-Modifying Code Hazard Detector

This block keeps the instruction side of a core coherent with its own stores. It watches two kinds of conflict. In the first, a store writes to a page whose instructions are held, already decoded, in the instruction cache. Each entry of the instruction translation table carries a bit that marks its page as "instructions present". Every store address is compared against the marked pages, and a match raises an invalidate request naming that page.

In the second, an instruction fetch reads a 64-byte line that a store has not yet written to memory. Pending stores sit in one of two places. A speculative store buffer holds stores that may still be squashed. A write-combining buffer holds stores that are committed but not yet drained. A fetch that hits a speculative store asks for a full pipeline flush. A fetch that hits only committed stores asks for a re-fetch of that fetch.

The surrounding core allocates store-buffer entries, commits them into write-combining slots, drains those slots, flushes the pipeline and fills or replaces translation entries. The block answers each store and each fetch with registered single-cycle requests.

Top module: `smc_guard`

## Requirements
- R1: During reset and on the first cycle after it, `inval_req`, `refetch_req` and `flush_req` are 0. Reset empties both pending-store buffers and clears every instruction-present bit, including any set before the reset.
- R2: A store (`st_alloc_vld`) to a page held by a table entry whose instruction-present bit is set raises `inval_req` on the cycle after the store. `inval_page` then equals the store address bits [31:12].
- R3: `ifill_vld` sets the instruction-present bit of entry `ifill_idx`. `itlb_repl_vld` loads a new page into entry `itlb_repl_idx` and clears that entry's bit. A store to a page whose entry bit is clear raises no `inval_req`. This holds for index 0 through index 127.
- R4: A store that raises `inval_req` clears the instruction-present bit of every matching entry. A later store to the same page raises no `inval_req` until the entry is filled again.
- R5: A fetch whose line (address bits [31:6]) equals that of a valid store-buffer entry raises `flush_req` on the next cycle. Lookups see the buffer contents from before the current edge, so a store allocated in the same cycle as the fetch is not matched.
- R6: A fetch whose line matches only a valid write-combining entry raises `refetch_req` on the next cycle.
- R7: A fetch that matches both buffers raises `flush_req` and not `refetch_req`. The two outputs are never high together.
- R8: Matching uses 64-byte lines. A fetch to another line of the same page raises no request.
- R9: `st_commit_vld` moves the line of store entry `st_commit_id` into write-combining slot `st_commit_wcb` and frees the store-buffer entry. After that, a fetch to the line raises a re-fetch, not a flush.
- R10: `pipe_flush` empties the store buffer. A store allocated in the flush cycle is dropped. A commit in the flush cycle still reaches its write-combining slot.
- R11: `wcb_drain_vld` frees slot `wcb_drain_id`. A commit into the same slot in the same cycle takes priority and leaves the slot valid.
- R12: Each request is high for exactly one cycle per triggering store or fetch. No request rises without a store or fetch on the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| itlb_repl_vld | input | 1 | Load a new page into a translation entry |
| itlb_repl_idx | input | 7 | Entry being replaced |
| itlb_repl_page | input | 20 | New page number (address bits [31:12]) |
| ifill_vld | input | 1 | Instructions from an entry's page were filled |
| ifill_idx | input | 7 | Entry whose page was filled |
| st_alloc_vld | input | 1 | Store allocated; its address is checked and buffered |
| st_alloc_id | input | 3 | Store-buffer entry allocated |
| st_alloc_addr | input | 32 | Physical address of the store |
| st_commit_vld | input | 1 | Store commits to the write-combining buffer |
| st_commit_id | input | 3 | Store-buffer entry committing |
| st_commit_wcb | input | 2 | Write-combining slot that receives it |
| wcb_drain_vld | input | 1 | A write-combining slot drained to memory |
| wcb_drain_id | input | 2 | Slot drained |
| pipe_flush | input | 1 | Pipeline flush; squashes speculative stores |
| fetch_vld | input | 1 | Instruction fetch presented |
| fetch_addr | input | 32 | Fetch address |
| inval_req | output | 1 | Invalidate cached instructions of `inval_page` |
| inval_page | output | 20 | Page to invalidate |
| refetch_req | output | 1 | Re-fetch request (committed-store hit) |
| flush_req | output | 1 | Full flush request (speculative-store hit) |

## Verification
Every request is registered once, so the result of a store or fetch presented in cycle N is visible during cycle N+1 only. Buffer and table updates from cycle N are first seen by lookups in cycle N+1. The bench drives one operation at a falling edge and reads all three requests at the next falling edge, before it drives anything else. This catches both a missing pulse and a pulse that lasts too long. The same-cycle cases are driven as single combined cycles, followed by a probing fetch or store one cycle later: allocate with fetch, flush with commit and allocate, commit with drain.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_REFETCH = 2'd1,
    ACT_FLUSH   = 2'd2
  } fetch_act_e;

  // A speculative hit outranks a committed hit.
  function automatic fetch_act_e pick_action(input logic spec_hit, input logic comm_hit);
    if (spec_hit)      return ACT_FLUSH;
    else if (comm_hit) return ACT_REFETCH;
    else               return ACT_NONE;
  endfunction

endpackage

// File: rtl/smc_inuse_tbl.sv
module smc_inuse_tbl #(
  parameter int ENTRIES = 128,
  parameter int PAGE_W  = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              repl_vld,
  input  logic [IDX_W-1:0]  repl_idx,
  input  logic [PAGE_W-1:0] repl_page,
  input  logic              fill_vld,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic              chk_vld,
  input  logic [PAGE_W-1:0] chk_page,
  output logic              chk_hit
);

  logic [PAGE_W-1:0]  page_q [ENTRIES];
  logic [ENTRIES-1:0] present_q;
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic repl_here, fill_here, kill_here;
    assign repl_here = repl_vld && (repl_idx == IDX_W'(g));
    assign fill_here = fill_vld && (fill_idx == IDX_W'(g));
    assign match[g]  = present_q[g] && (page_q[g] == chk_page);
    assign kill_here = chk_vld && match[g];

    always_ff @(posedge clk) begin
      if (repl_here) page_q[g] <= repl_page;
    end

    // Replacement and invalidation both win over a fill in the same cycle.
    always_ff @(posedge clk) begin
      if (!rst_n) present_q[g] <= 1'b0;
      else        present_q[g] <= (present_q[g] || fill_here) && !repl_here && !kill_here;
    end
  end

  assign chk_hit = chk_vld && (|match);

endmodule

// File: rtl/smc_pend_buf.sv
module smc_pend_buf #(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26,
  localparam int ID_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_vld,
  input  logic [ID_W-1:0]   set_id,
  input  logic [LINE_W-1:0] set_line,
  input  logic [DEPTH-1:0]  clr_mask,
  input  logic [LINE_W-1:0] look_line,
  output logic              look_hit,
  output logic [LINE_W-1:0] line_o [DEPTH],
  output logic [DEPTH-1:0]  valid_o
);

  logic [DEPTH-1:0]  valid_q;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [DEPTH-1:0]  eq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic set_here;
    assign set_here = set_vld && (set_id == ID_W'(g));
    assign eq[g]    = valid_q[g] && (line_q[g] == look_line);
    assign line_o[g] = line_q[g];

    always_ff @(posedge clk) begin
      if (set_here) line_q[g] <= set_line;
    end

    // Setting a slot takes priority over clearing it.
    always_ff @(posedge clk) begin
      if (!rst_n)          valid_q[g] <= 1'b0;
      else if (set_here)   valid_q[g] <= 1'b1;
      else if (clr_mask[g]) valid_q[g] <= 1'b0;
    end
  end

  assign look_hit = |eq;
  assign valid_o  = valid_q;

endmodule

// File: rtl/smc_guard.sv
module smc_guard
  import smc_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int PAGE_SHIFT   = 12,
  parameter int LINE_SHIFT   = 6,
  parameter int ITLB_ENTRIES = 128,
  parameter int SB_DEPTH     = 8,
  parameter int WCB_DEPTH    = 4,
  localparam int PAGE_W      = ADDR_W - PAGE_SHIFT,
  localparam int LINE_W      = ADDR_W - LINE_SHIFT,
  localparam int ITLB_IDX    = $clog2(ITLB_ENTRIES),
  localparam int SB_IDX      = $clog2(SB_DEPTH),
  localparam int WCB_IDX     = $clog2(WCB_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                itlb_repl_vld,
  input  logic [ITLB_IDX-1:0] itlb_repl_idx,
  input  logic [PAGE_W-1:0]   itlb_repl_page,
  input  logic                ifill_vld,
  input  logic [ITLB_IDX-1:0] ifill_idx,
  input  logic                st_alloc_vld,
  input  logic [SB_IDX-1:0]   st_alloc_id,
  input  logic [ADDR_W-1:0]   st_alloc_addr,
  input  logic                st_commit_vld,
  input  logic [SB_IDX-1:0]   st_commit_id,
  input  logic [WCB_IDX-1:0]  st_commit_wcb,
  input  logic                wcb_drain_vld,
  input  logic [WCB_IDX-1:0]  wcb_drain_id,
  input  logic                pipe_flush,
  input  logic                fetch_vld,
  input  logic [ADDR_W-1:0]   fetch_addr,
  output logic                inval_req,
  output logic [PAGE_W-1:0]   inval_page,
  output logic                refetch_req,
  output logic                flush_req
);

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LINE_SHIFT];
  endfunction

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_SHIFT];
  endfunction

  // Named internal events, visible to the bound checker.
  logic [PAGE_W-1:0]  store_page_w;
  logic [LINE_W-1:0]  store_line_w;
  logic [LINE_W-1:0]  fetch_line_w;
  logic               store_hit_w;
  logic               sb_hit_w;
  logic               wcb_hit_w;
  fetch_act_e         fetch_act_w;
  logic [LINE_W-1:0]  commit_line_w;
  logic [SB_DEPTH-1:0]  sb_valid_w;
  logic [WCB_DEPTH-1:0] wcb_valid_w;
  logic [SB_DEPTH-1:0]  sb_clr_w;
  logic [WCB_DEPTH-1:0] wcb_clr_w;
  logic [LINE_W-1:0]  sb_lines_w  [SB_DEPTH];
  logic [LINE_W-1:0]  wcb_lines_w [WCB_DEPTH];

  assign store_page_w = page_of(st_alloc_addr);
  assign store_line_w = line_of(st_alloc_addr);
  assign fetch_line_w = line_of(fetch_addr);

  // Case 1: store against pages holding cached instructions.
  smc_inuse_tbl #(
    .ENTRIES (ITLB_ENTRIES),
    .PAGE_W  (PAGE_W)
  ) u_inuse (
    .clk       (clk),
    .rst_n     (rst_n),
    .repl_vld  (itlb_repl_vld),
    .repl_idx  (itlb_repl_idx),
    .repl_page (itlb_repl_page),
    .fill_vld  (ifill_vld),
    .fill_idx  (ifill_idx),
    .chk_vld   (st_alloc_vld),
    .chk_page  (store_page_w),
    .chk_hit   (store_hit_w)
  );

  // Clear masks: commit frees its entry, flush frees all; drain frees one slot.
  for (genvar g = 0; g < SB_DEPTH; g++) begin : g_sbclr
    assign sb_clr_w[g] = pipe_flush || (st_commit_vld && (st_commit_id == SB_IDX'(g)));
  end
  for (genvar g = 0; g < WCB_DEPTH; g++) begin : g_wcbclr
    assign wcb_clr_w[g] = wcb_drain_vld && (wcb_drain_id == WCB_IDX'(g));
  end

  assign commit_line_w = sb_lines_w[st_commit_id];

  // Case 2a: speculative stores.
  smc_pend_buf #(
    .DEPTH  (SB_DEPTH),
    .LINE_W (LINE_W)
  ) u_sb (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vld   (st_alloc_vld && !pipe_flush),
    .set_id    (st_alloc_id),
    .set_line  (store_line_w),
    .clr_mask  (sb_clr_w),
    .look_line (fetch_line_w),
    .look_hit  (sb_hit_w),
    .line_o    (sb_lines_w),
    .valid_o   (sb_valid_w)
  );

  // Case 2b: committed stores awaiting drain.
  smc_pend_buf #(
    .DEPTH  (WCB_DEPTH),
    .LINE_W (LINE_W)
  ) u_wcb (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vld   (st_commit_vld),
    .set_id    (st_commit_wcb),
    .set_line  (commit_line_w),
    .clr_mask  (wcb_clr_w),
    .look_line (fetch_line_w),
    .look_hit  (wcb_hit_w),
    .line_o    (wcb_lines_w),
    .valid_o   (wcb_valid_w)
  );

  assign fetch_act_w = fetch_vld ? pick_action(sb_hit_w, wcb_hit_w) : ACT_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inval_req   <= 1'b0;
      inval_page  <= '0;
      refetch_req <= 1'b0;
      flush_req   <= 1'b0;
    end else begin
      inval_req   <= store_hit_w;
      if (store_hit_w) inval_page <= store_page_w;
      refetch_req <= (fetch_act_w == ACT_REFETCH);
      flush_req   <= (fetch_act_w == ACT_FLUSH);
    end
  end

endmodule

// File: rtl/smc_guard_chk.sv
module smc_guard_chk #(
  parameter int PAGE_W    = 20,
  parameter int LINE_W    = 26,
  parameter int SB_DEPTH  = 8,
  parameter int WCB_DEPTH = 4,
  localparam int WCB_IDX  = $clog2(WCB_DEPTH)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 st_alloc_vld,
  input logic                 st_commit_vld,
  input logic [WCB_IDX-1:0]   st_commit_wcb,
  input logic                 wcb_drain_vld,
  input logic [WCB_IDX-1:0]   wcb_drain_id,
  input logic                 pipe_flush,
  input logic                 fetch_vld,
  input logic                 inval_req,
  input logic [PAGE_W-1:0]    inval_page,
  input logic                 refetch_req,
  input logic                 flush_req,
  input logic [PAGE_W-1:0]    store_page_w,
  input logic                 sb_hit_w,
  input logic                 wcb_hit_w,
  input logic [LINE_W-1:0]    commit_line_w,
  input logic [SB_DEPTH-1:0]  sb_valid_w,
  input logic [WCB_DEPTH-1:0] wcb_valid_w,
  input logic [LINE_W-1:0]    wcb_lines_w [WCB_DEPTH]
);

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_req && refetch_req));

  p_flush_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(fetch_vld && sb_hit_w));

  p_refetch_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refetch_req |-> $past(fetch_vld && wcb_hit_w && !sb_hit_w));

  p_inval_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inval_req |-> ($past(st_alloc_vld) && inval_page == $past(store_page_w)));

  p_no_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fetch_vld) |-> (!flush_req && !refetch_req));

  p_sb_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_flush |=> (sb_valid_w == '0));

  p_commit_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_commit_vld |=> (wcb_valid_w[$past(st_commit_wcb)] &&
                       wcb_lines_w[$past(st_commit_wcb)] == $past(commit_line_w)));

  p_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wcb_drain_vld && !(st_commit_vld && st_commit_wcb == wcb_drain_id))
      |=> !wcb_valid_w[$past(wcb_drain_id)]);

endmodule

bind smc_guard smc_guard_chk #(
  .PAGE_W    (PAGE_W),
  .LINE_W    (LINE_W),
  .SB_DEPTH  (SB_DEPTH),
  .WCB_DEPTH (WCB_DEPTH)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .st_alloc_vld  (st_alloc_vld),
  .st_commit_vld (st_commit_vld),
  .st_commit_wcb (st_commit_wcb),
  .wcb_drain_vld (wcb_drain_vld),
  .wcb_drain_id  (wcb_drain_id),
  .pipe_flush    (pipe_flush),
  .fetch_vld     (fetch_vld),
  .inval_req     (inval_req),
  .inval_page    (inval_page),
  .refetch_req   (refetch_req),
  .flush_req     (flush_req),
  .store_page_w  (store_page_w),
  .sb_hit_w      (sb_hit_w),
  .wcb_hit_w     (wcb_hit_w),
  .commit_line_w (commit_line_w),
  .sb_valid_w    (sb_valid_w),
  .wcb_valid_w   (wcb_valid_w),
  .wcb_lines_w   (wcb_lines_w)
);

// File: tb/smc_guard_test.sv
module smc_guard_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        itlb_repl_vld = 1'b0;
  logic [6:0]  itlb_repl_idx = '0;
  logic [19:0] itlb_repl_page = '0;
  logic        ifill_vld = 1'b0;
  logic [6:0]  ifill_idx = '0;
  logic        st_alloc_vld = 1'b0;
  logic [2:0]  st_alloc_id = '0;
  logic [31:0] st_alloc_addr = '0;
  logic        st_commit_vld = 1'b0;
  logic [2:0]  st_commit_id = '0;
  logic [1:0]  st_commit_wcb = '0;
  logic        wcb_drain_vld = 1'b0;
  logic [1:0]  wcb_drain_id = '0;
  logic        pipe_flush = 1'b0;
  logic        fetch_vld = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        inval_req;
  logic [19:0] inval_page;
  logic        refetch_req;
  logic        flush_req;

  int nchk  = 0;
  int nfail = 0;

  always #2 clk = ~clk;  // 250 MHz

  smc_guard uut (
    .clk(clk), .rst_n(rst_n),
    .itlb_repl_vld(itlb_repl_vld), .itlb_repl_idx(itlb_repl_idx), .itlb_repl_page(itlb_repl_page),
    .ifill_vld(ifill_vld), .ifill_idx(ifill_idx),
    .st_alloc_vld(st_alloc_vld), .st_alloc_id(st_alloc_id), .st_alloc_addr(st_alloc_addr),
    .st_commit_vld(st_commit_vld), .st_commit_id(st_commit_id), .st_commit_wcb(st_commit_wcb),
    .wcb_drain_vld(wcb_drain_vld), .wcb_drain_id(wcb_drain_id),
    .pipe_flush(pipe_flush), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .inval_req(inval_req), .inval_page(inval_page),
    .refetch_req(refetch_req), .flush_req(flush_req)
  );

  localparam logic [2:0] OP_FILL = 3'd0, OP_REPL = 3'd1, OP_STORE = 3'd2,
                         OP_COMMIT = 3'd3, OP_DRAIN = 3'd4, OP_FETCH = 3'd5, OP_FLUSH = 3'd6;

  // exp = {inval, refetch, flush}. For COMMIT addr[1:0] is the slot; for DRAIN likewise.
  typedef struct packed {
    logic [2:0]  op;
    logic [6:0]  id;
    logic [31:0] addr;
    logic [2:0]  exp;
  } vec_t;

  localparam int NVEC = 25;
  localparam vec_t VEC [NVEC] = '{
    '{OP_FETCH,  7'd0,   32'h1000_0040, 3'b000},  // R1 empty buffers
    '{OP_REPL,   7'd3,   32'h1234_5000, 3'b000},
    '{OP_STORE,  7'd0,   32'h1234_5080, 3'b000},  // R3 bit clear
    '{OP_FILL,   7'd3,   32'h0,         3'b000},
    '{OP_STORE,  7'd1,   32'h1234_50C4, 3'b100},  // R2
    '{OP_STORE,  7'd2,   32'h1234_5100, 3'b000},  // R4 bit cleared
    '{OP_FETCH,  7'd0,   32'h1234_5088, 3'b001},  // R5
    '{OP_FETCH,  7'd0,   32'h1234_5140, 3'b000},  // R8
    '{OP_COMMIT, 7'd0,   32'h1,         3'b000},
    '{OP_FETCH,  7'd0,   32'h1234_50BC, 3'b010},  // R6 R9
    '{OP_STORE,  7'd3,   32'h1234_5090, 3'b000},
    '{OP_FETCH,  7'd0,   32'h1234_5080, 3'b001},  // R7
    '{OP_DRAIN,  7'd0,   32'h1,         3'b000},
    '{OP_FETCH,  7'd0,   32'h1234_5080, 3'b001},  // R11
    '{OP_FLUSH,  7'd0,   32'h0,         3'b000},
    '{OP_FETCH,  7'd0,   32'h1234_5080, 3'b000},  // R10
    '{OP_FETCH,  7'd0,   32'h1234_50C0, 3'b000},  // R10
    '{OP_FETCH,  7'd0,   32'h1234_5100, 3'b000},  // R10
    '{OP_FILL,   7'd3,   32'h0,         3'b000},
    '{OP_REPL,   7'd3,   32'h1234_5000, 3'b000},
    '{OP_STORE,  7'd4,   32'h1234_5000, 3'b000},  // R3 replace clears
    '{OP_REPL,   7'd127, 32'hABCD_E000, 3'b000},
    '{OP_FILL,   7'd127, 32'h0,         3'b000},
    '{OP_STORE,  7'd5,   32'hABCD_EFC0, 3'b100},  // R2 R3 top index
    '{OP_STORE,  7'd6,   32'hABCD_E000, 3'b000}   // R4
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    itlb_repl_vld = 1'b0; ifill_vld = 1'b0; st_alloc_vld = 1'b0; st_commit_vld = 1'b0;
    wcb_drain_vld = 1'b0; pipe_flush = 1'b0; fetch_vld = 1'b0;
  endtask

  // Inputs set at a falling edge are taken at the next rising edge; results read at the falling edge after.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic expect3(input string req, input logic inv, input logic rf, input logic fl);
    chk(req, "inval_req", 32'(inval_req), 32'(inv));
    chk(req, "refetch_req", 32'(refetch_req), 32'(rf));
    chk(req, "flush_req", 32'(flush_req), 32'(fl));
  endtask

  task automatic do_fetch(input logic [31:0] a);
    fetch_vld = 1'b1; fetch_addr = a;
  endtask

  task automatic do_store(input logic [2:0] id, input logic [31:0] a);
    st_alloc_vld = 1'b1; st_alloc_id = id; st_alloc_addr = a;
  endtask

  task automatic do_commit(input logic [2:0] id, input logic [1:0] slot);
    st_commit_vld = 1'b1; st_commit_id = id; st_commit_wcb = slot;
  endtask

  initial begin
    #(4 * 20000);
    nfail++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect3("R1", 1'b0, 1'b0, 1'b0);  // during reset
    rst_n = 1'b1;
    step();
    expect3("R1", 1'b0, 1'b0, 1'b0);  // first cycle after reset

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i].op)
        OP_FILL:   begin ifill_vld = 1'b1; ifill_idx = VEC[i].id; end
        OP_REPL:   begin itlb_repl_vld = 1'b1; itlb_repl_idx = VEC[i].id; itlb_repl_page = VEC[i].addr[31:12]; end
        OP_STORE:  do_store(VEC[i].id[2:0], VEC[i].addr);
        OP_COMMIT: do_commit(VEC[i].id[2:0], VEC[i].addr[1:0]);
        OP_DRAIN:  begin wcb_drain_vld = 1'b1; wcb_drain_id = VEC[i].addr[1:0]; end
        OP_FETCH:  do_fetch(VEC[i].addr);
        default:   pipe_flush = 1'b1;
      endcase
      step();
      expect3("R2 R5 R6 R7 R12 vector", VEC[i].exp[2], VEC[i].exp[1], VEC[i].exp[0]);
      if (VEC[i].exp[2]) chk("R2", "inval_page", 32'(inval_page), 32'(VEC[i].addr[31:12]));
    end

    // R5: a store allocated in the fetch cycle is not seen until the next cycle.
    do_store(3'd0, 32'h2000_0000); do_fetch(32'h2000_0000);
    step(); expect3("R5 same-cycle", 1'b0, 1'b0, 1'b0);
    do_fetch(32'h2000_003F);
    step(); expect3("R5 next-cycle", 1'b0, 1'b0, 1'b1);

    // R10: commit survives a flush; an allocate in the flush cycle is dropped.
    pipe_flush = 1'b1; do_commit(3'd0, 2'd2); do_store(3'd1, 32'h3000_0000);
    step(); expect3("R10 flush cycle", 1'b0, 1'b0, 1'b0);
    do_fetch(32'h2000_0010);
    step(); expect3("R10 commit kept", 1'b0, 1'b1, 1'b0);
    do_fetch(32'h3000_0000);
    step(); expect3("R10 alloc dropped", 1'b0, 1'b0, 1'b0);

    // R11: commit and drain of the same slot in one cycle leaves it valid.
    do_store(3'd2, 32'h4000_0000);
    step();
    do_commit(3'd2, 2'd3); wcb_drain_vld = 1'b1; wcb_drain_id = 2'd3;
    step();
    do_fetch(32'h4000_0020);
    step(); expect3("R11 commit wins", 1'b0, 1'b1, 1'b0);
    wcb_drain_vld = 1'b1; wcb_drain_id = 2'd3;
    step();
    do_fetch(32'h4000_0020);
    step(); expect3("R11 drained", 1'b0, 1'b0, 1'b0);

    // R1: reset mid-run clears buffers and instruction-present bits.
    do_store(3'd3, 32'h5000_0000); ifill_vld = 1'b1; ifill_idx = 7'd127;
    step();
    rst_n = 1'b0;
    step(); expect3("R1 in reset", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    step(); expect3("R1 after reset", 1'b0, 1'b0, 1'b0);
    do_fetch(32'h5000_0000);
    step(); expect3("R1 sb emptied", 1'b0, 1'b0, 1'b0);
    do_fetch(32'h2000_0000);
    step(); expect3("R1 wcb emptied", 1'b0, 1'b0, 1'b0);
    do_store(3'd4, 32'hABCD_E000);
    step(); expect3("R1 present bits cleared", 1'b0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule